// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a slower peripheral bus clock from the system clock. The divide ratio is a 7-bit field plus one, so any ratio from 1 to 128 can be selected. A single bus register holds the ratio field, an output enable bit and a read-only ready flag. Software writes a new ratio only while ready is high. Ready then drops, and it returns once the new ratio is running.

A new ratio never takes effect in the middle of an output period. It is held pending and loaded on the edge that closes the current period, so the output never shows a shortened pulse. The enable bit can be written through the main address, or changed on its own through a set alias and a clear alias, with no read-modify-write. A write to the ratio field also needs the system unlock input, which is driven by logic outside this block.

Top module: `pbclk_div`

## Requirements
- R1: After reset the register reads enable (bit 15) = 0, ready (bit 11) = 1 and ratio field (bits 6:0) = RESET_DIV (default 1, read value 16'h0801), and pbClk is low.
- R2: With ratio field F > 0, pbClk has a period of F+1 system cycles. It is high for ceil((F+1)/2) cycles and low for the rest: F=1 gives 1/1, F=2 gives 2/1, F=4 gives 3/2, F=20 gives 11/10 and F=127 gives 64/64.
- R3: With ratio field 0 and the output enabled, pbClk follows the system clock: high in its high phase and low in its low phase.
- R4: A write to the main address (busAddr = 0) while unlockOk = 1 and ready = 1 is accepted. From the next cycle, bits 6:0 read the written value and ready reads 0.
- R5: An accepted ratio is loaded only on the edge that ends the current output period. Ready returns to 1 on that same edge, within old ratio + 1 cycles of the write. Every complete period after that uses the new ratio.
- R6: A ratio write to the main address while ready = 0 leaves the ratio field unchanged.
- R7: A ratio write to the main address while unlockOk = 0 leaves the ratio field unchanged.
- R8: Bit 15 of a main-address write always sets the enable bit, with or without unlock. A write to the set alias (busAddr = 1) with bit 15 = 1 sets enable, and a write to the clear alias (busAddr = 2) with bit 15 = 1 clears it. Alias writes never change the ratio field.
- R9: A cleared enable holds pbClk low, starting at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| unlockOk | input | 1 | System unlock state; a ratio write needs it high |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | 0 main, 1 set alias, 2 clear alias, 3 no effect |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Register read value (enable, ready, ratio field) |
| pbClk | output | 1 | Divided, gated peripheral bus clock |

## Verification
The assertions assume that the bus inputs and unlockOk are known and stable around every rising edge. They also assume that busRdata reflects the register contents one cycle after a write. The bench meets this by driving all inputs on the falling edge and holding each write for exactly one cycle. Back-to-back writes are issued on consecutive falling edges, so that a write can land while a reload is still pending. The output waveform is sampled just after each rising edge; the ratio-one mode is also sampled after the falling edge.

// File: rtl/pbclk_div_pkg.sv
package pbclk_div_pkg;

  // bus address decode; the set and clear aliases act on the enable bit only
  typedef enum logic [1:0] {
    ADDR_MAIN = 2'd0,
    ADDR_SET  = 2'd1,
    ADDR_CLR  = 2'd2,
    ADDR_NONE = 2'd3
  } pbAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDiv;  // pending ratio is loaded at this period boundary
    logic enReq;    // enable level to adopt at the next boundary
  } pbStb_t;

endpackage

// File: rtl/pbclk_ctrl.sv
module pbclk_ctrl
  import pbclk_div_pkg::*;
#(
  parameter int DIV_W     = 7,
  parameter int DATA_W    = 16,
  parameter int EN_BIT    = 15,
  parameter int RDY_BIT   = 11,
  parameter int RESET_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unlockOk,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              periodEnd,
  output pbStb_t            stb,
  output logic [DIV_W-1:0]  newDiv,
  output logic [DATA_W-1:0] busRdata
);

  logic             pend;
  logic             enReg;
  logic [DIV_W-1:0] divField;
  logic             wrMain;
  logic             wrSet;
  logic             wrClr;
  logic             acceptDiv;
  logic             unusedBits;

  assign wrMain    = busWe && (busAddr == ADDR_MAIN);
  assign wrSet     = busWe && (busAddr == ADDR_SET) && busWdata[EN_BIT];
  assign wrClr     = busWe && (busAddr == ADDR_CLR) && busWdata[EN_BIT];
  assign acceptDiv = wrMain && unlockOk && !pend;
  assign unusedBits = ^busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= 1'b0;
      enReg    <= 1'b0;
      divField <= DIV_W'(RESET_DIV);
    end else begin
      if (acceptDiv) begin
        divField <= busWdata[DIV_W-1:0];
        pend     <= 1'b1;
      end else if (pend && periodEnd) begin
        pend <= 1'b0;
      end
      if (wrMain) enReg <= busWdata[EN_BIT];
      else if (wrSet) enReg <= 1'b1;
      else if (wrClr) enReg <= 1'b0;
    end
  end

  always_comb begin
    stb.loadDiv = pend && periodEnd;
    stb.enReq   = enReg;
    newDiv      = divField;
  end

  always_comb begin
    busRdata                = '0;
    busRdata[DIV_W-1:0]     = divField;
    busRdata[RDY_BIT]       = !pend;
    busRdata[EN_BIT]        = enReg;
  end

endmodule

// File: rtl/pbclk_dpath.sv
module pbclk_dpath
  import pbclk_div_pkg::*;
#(
  parameter int DIV_W     = 7,
  parameter int RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pbStb_t           stb,
  input  logic [DIV_W-1:0] newDiv,
  output logic             periodEnd,
  output logic             pbClk
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  localparam logic [DIV_W:0]   TWO = (DIV_W+1)'(2);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] liveDiv;
  logic             enLive;
  logic             hiQ;
  logic             gateN;
  logic             ratioOne;
  logic [DIV_W:0]   highLen;
  logic [DIV_W:0]   cntNext;

  // high phase length = ceil(ratio/2) with ratio = field + 1
  assign highLen   = ({1'b0, liveDiv} + TWO) >> 1;
  assign cntNext   = {1'b0, cnt + ONE};
  assign periodEnd = (cnt == liveDiv);
  assign ratioOne  = (liveDiv == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      liveDiv <= DIV_W'(RESET_DIV);
      enLive  <= 1'b0;
      hiQ     <= 1'b0;
    end else if (periodEnd) begin
      cnt    <= '0;
      enLive <= stb.enReq;
      hiQ    <= stb.enReq;
      if (stb.loadDiv) liveDiv <= newDiv;
    end else begin
      cnt <= cnt + ONE;
      hiQ <= enLive && (cntNext < highLen);
    end
  end

  // gate for the pass-through mode changes only while clk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateN <= 1'b0;
    else       gateN <= enLive && ratioOne;
  end

  assign pbClk = ratioOne ? (clk & gateN) : hiQ;

endmodule

// File: rtl/pbclk_div.sv
module pbclk_div
  import pbclk_div_pkg::*;
#(
  parameter int DIV_W     = 7,
  parameter int DATA_W    = 16,
  parameter int EN_BIT    = 15,
  parameter int RDY_BIT   = 11,
  parameter int RESET_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unlockOk,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pbClk
);

  pbStb_t           stb;
  logic [DIV_W-1:0] newDiv;
  logic             periodEnd;

  pbclk_ctrl #(
    .DIV_W(DIV_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT),
    .RDY_BIT(RDY_BIT), .RESET_DIV(RESET_DIV)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .unlockOk(unlockOk), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .periodEnd(periodEnd),
    .stb(stb), .newDiv(newDiv), .busRdata(busRdata)
  );

  pbclk_dpath #(
    .DIV_W(DIV_W), .RESET_DIV(RESET_DIV)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .newDiv(newDiv),
    .periodEnd(periodEnd), .pbClk(pbClk)
  );

endmodule

// File: rtl/pbclk_div_chk.sv
module pbclk_div_chk #(
  parameter int DIV_W   = 7,
  parameter int DATA_W  = 16,
  parameter int EN_BIT  = 15,
  parameter int RDY_BIT = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              unlockOk,
  input logic              busWe,
  input logic [1:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              periodEnd
);

  logic unusedChk;
  assign unusedChk = ^busWdata;

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd0 && unlockOk && busRdata[RDY_BIT])
    |=> (!busRdata[RDY_BIT] && busRdata[DIV_W-1:0] == $past(busWdata[DIV_W-1:0])));

  assert_ready_at_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdata[RDY_BIT]) |-> $past(periodEnd));

  assert_busy_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd0 && !busRdata[RDY_BIT])
    |=> $stable(busRdata[DIV_W-1:0]));

  assert_locked_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd0 && !unlockOk)
    |=> $stable(busRdata[DIV_W-1:0]));

  assert_set_alias_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd1 && busWdata[EN_BIT])
    |=> (busRdata[EN_BIT] && $stable(busRdata[DIV_W-1:0])));

  assert_clr_alias_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd2 && busWdata[EN_BIT])
    |=> (!busRdata[EN_BIT] && $stable(busRdata[DIV_W-1:0])));

endmodule

bind pbclk_div pbclk_div_chk #(
  .DIV_W(DIV_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT), .RDY_BIT(RDY_BIT)
) chk_i (
  .clk(clk), .rstN(rstN), .unlockOk(unlockOk), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .periodEnd(periodEnd)
);

// File: tb/pbclk_div_tb_top.sv
`timescale 1ns/1ps
module pbclk_div_tb_top;
  import pbclk_div_pkg::*;

  typedef struct packed { int hi; int lo; } pair_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        unlockOk = 1'b1;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        pbClk;

  int    testCnt = 0;
  int    failCnt = 0;
  bit    monOn = 1'b0;
  pair_t expQ[$];

  always #2 clk = ~clk;

  pbclk_div dut_i (
    .clk(clk), .rstN(rstN), .unlockOk(unlockOk), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pbClk(pbClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the next falling edge
  task automatic busWrite(input logic [1:0] addr, input logic [15:0] data);
    busWe = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busWe = 1'b0; busAddr = 2'd0; busWdata = '0;
  endtask

  task automatic waitReady(output int cycles);
    cycles = 0;
    while (!busRdata[11] && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  // scoreboard driver: push expected periods, let the monitor consume them
  task automatic runSb(input int hi, input int lo, input int n);
    int guard;
    for (int i = 0; i < n; i++) expQ.push_back('{hi: hi, lo: lo});
    monOn = 1'b1;
    guard = 0;
    while (expQ.size() > 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    monOn = 1'b0;
    check(expQ.size() == 0, "R2 periods observed", n - expQ.size(), n);
    expQ.delete();
    @(negedge clk);
  endtask

  // monitor: measure high and low run lengths of pbClk after each rising edge
  initial begin
    bit prevS = 1'b0;
    bit started = 1'b0;
    int hiC = 0;
    int loC = 0;
    forever begin
      @(posedge clk); #1;
      if (!monOn) begin
        started = 1'b0;
      end else if (pbClk && !prevS) begin
        if (started && expQ.size() > 0) begin
          pair_t e;
          e = expQ.pop_front();
          check(hiC == e.hi && loC == e.lo, "R2 hi*1000+lo", hiC*1000+loC, e.hi*1000+e.lo);
        end
        started = 1'b1; hiC = 1; loC = 0;
      end else if (started) begin
        if (pbClk) hiC++; else loC++;
      end
      prevS = pbClk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int cyc;
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busRdata == 16'h0801, "R1 reset register", busRdata, 16'h0801);
    bad = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (pbClk) bad++; end
    check(bad == 0, "R1 pbClk low after reset", bad, 0);

    // R8 set alias enables, ratio unchanged; R2 ratio 2
    busWrite(ADDR_SET, 16'h8000);
    check(busRdata[15] == 1'b1, "R8 set alias enable", busRdata[15], 1);
    check(busRdata[6:0] == 7'd1, "R8 set alias keeps ratio", busRdata[6:0], 1);
    runSb(1, 1, 3);

    // R4 accepted write, ratio 3
    busWrite(ADDR_MAIN, 16'h8002);
    check(busRdata[11] == 1'b0, "R4 ready low after write", busRdata[11], 0);
    check(busRdata[6:0] == 7'd2, "R4 readback", busRdata[6:0], 2);
    waitReady(cyc);
    runSb(2, 1, 3);

    // R6 write while ready low is ignored
    busWrite(ADDR_MAIN, 16'h8014);
    busWrite(ADDR_MAIN, 16'h8007);
    check(busRdata[6:0] == 7'd20, "R6 busy write ignored", busRdata[6:0], 20);
    waitReady(cyc);
    runSb(11, 10, 3);

    // R5 ready returns within old ratio + 1 cycles, new ratio used
    busWrite(ADDR_MAIN, 16'h8004);
    waitReady(cyc);
    check(cyc <= 21 && busRdata[11], "R5 ready window", cyc, 21);
    runSb(3, 2, 3);

    // R7 locked write ignored
    unlockOk = 1'b0;
    busWrite(ADDR_MAIN, 16'h8009);
    check(busRdata[6:0] == 7'd4 && busRdata[11], "R7 locked write ignored", busRdata[6:0], 4);
    unlockOk = 1'b1;

    // R2 ratio 128
    busWrite(ADDR_MAIN, 16'h807F);
    waitReady(cyc);
    runSb(64, 64, 3);

    // R3 pass-through
    busWrite(ADDR_MAIN, 16'h8000);
    waitReady(cyc);
    repeat (3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(posedge clk); #1; if (!pbClk) bad++; end
    check(bad == 0, "R3 high with clk", bad, 0);
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); #1; if (pbClk) bad++; end
    check(bad == 0, "R3 low with clk", bad, 0);
    @(negedge clk);

    // R8 clear alias; R9 gated output
    busWrite(ADDR_CLR, 16'h8000);
    check(busRdata[15] == 1'b0 && busRdata[6:0] == 7'd0, "R8 clear alias", busRdata, 16'h0800);
    busWrite(ADDR_MAIN, 16'h0001);
    waitReady(cyc);
    repeat (4) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 20; i++) begin @(posedge clk); #1; if (pbClk) bad++; end
    check(bad == 0, "R9 gated low", bad, 0);
    @(negedge clk);
    busWrite(ADDR_SET, 16'h8000);
    runSb(1, 1, 2);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule